// File: doc/BRIEF.md
# Configurable Output/Buried Register Macrocell

This block is one cell placed between the sum-term plane of a programmable logic array and either a device pin or a pure feedback path. It takes a data sum term, an enable/clock sum term, a shared output clock, a shared active-high reset term and a per-pin output-enable term. A static two-bit mode field selects one of three behaviours. In the first, the data term passes straight through. In the second, a D register is clocked directly by the enable sum term, so the clock comes from array logic. In the third, a D register runs on the shared clock and the enable term acts as a load enable, which holds state for counters and state machines. Two polarity bits invert the data term and the enable term before use.

The cell value drives the pin through an inverting tri-state buffer. A cleared register therefore appears as a high level on an enabled pin. The true form of the cell value always feeds back to the array. A second feedback returns whatever the pad carries, so the cell can serve as an input, or be buried dynamically, by dropping its output enable. A parameter builds a buried variant. That variant drives no pin and returns both the true and the complemented state. For test, a preload port forces any value into the register, including states that normal operation cannot reach, and a diagnostic output always shows the register contents.

The cell holds one bit of state, the register. Three transitions update it: load (a qualifying clock edge with the enable satisfied), hold (a clock edge with the enable unsatisfied, or any edge in a mode that does not use the register), and preload (a forced load on the active edge). An asynchronous clear overrides all three.

Top module: `pin_macrocell`

## Requirements
- R1: With `mode` = 2'b00 (pass-through), `fb_true` equals `d_term` XOR `d_inv` with no clock involved, and `pin_drive` is its inverse.
- R2: With `mode` = 2'b10 (gated register), each rising `oclk` edge loads `d_term` XOR `d_inv` when the effective enable is 1, and holds the register when the effective enable is 0.
- R3: With `mode` = 2'b01 (term-clocked register), the register loads the effective data on every rising edge of the effective enable term. `oclk` edges and falling enable edges leave it unchanged.
- R4: The effective enable is `e_term` XOR `e_inv`. With `e_inv` = 1, a low `e_term` enables the load in gated mode and a falling `e_term` clocks the register in term-clocked mode.
- R5: A high `rst_term` clears the register to 0 at once, without waiting for a clock edge. It wins over a clock edge that arrives while it is high. In a register mode, `pin_drive` is then 1.
- R6: For a pin cell, `pin_oe` follows `oe_term`, and `pin_drive` is the inverse of `fb_true`.
- R7: `fb_pin` returns `pin_in` whatever the value of `oe_term`. With `oe_term` = 0, `fb_true` still carries the cell value, so the cell is buried while the pin serves as an input.
- R8: In the buried variant (`BURIED` = 1), `pin_oe` stays 0 even when `oe_term` is 1, `fb_pin` is 0, and `fb_comp` is the inverse of `fb_true`.
- R9: A high `pl_en` on the register's active clock edge loads `pl_val`, whatever the data or the enable. In pass-through mode, that edge is an `oclk` edge.
- R10: `diag_q` shows the register contents in every mode, including pass-through, where the register does not drive `fb_true`.
- R11: `mode` = 2'b11 behaves exactly like pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oclk | input | 1 | Shared output clock |
| rst_term | input | 1 | Shared asynchronous reset term, active high |
| mode | input | 2 | 00 pass-through, 01 term-clocked, 10 gated, 11 as 00 |
| d_inv | input | 1 | Data-term polarity inversion |
| e_inv | input | 1 | Enable-term polarity inversion |
| d_term | input | 1 | Data sum term |
| e_term | input | 1 | Enable/clock sum term |
| oe_term | input | 1 | Output-enable product term |
| pl_en | input | 1 | Preload strobe |
| pl_val | input | 1 | Preload value |
| pin_in | input | 1 | Level seen at the pad |
| pin_drive | output | 1 | Inverted cell value toward the pad |
| pin_oe | output | 1 | Pad driver enable |
| fb_true | output | 1 | Direct feedback, true form |
| fb_comp | output | 1 | Direct feedback, complemented form |
| fb_pin | output | 1 | Feedback taken from the pad |
| diag_q | output | 1 | Register contents for diagnostics |

## Verification
A wrong register value appears on `fb_true`, `diag_q` and, inverted, on `pin_drive` one edge after the fault. The edge is an `oclk` edge in gated mode or an enable edge in term-clocked mode. A flaw in the clock selection shows as a load on the wrong clock source, so the bench runs `oclk` while it holds the enable term still, and moves the enable term between `oclk` edges. A reset that depends on a clock shows up when the bench checks the outputs a nanosecond after `rst_term` rises, before any edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB    = 2'b00,
        MODE_TERMCLK = 2'b01,
        MODE_GATED   = 2'b10,
        MODE_RSVD    = 2'b11
    } cell_mode_e;

    function automatic logic mode_is_reg(input cell_mode_e m);
        return (m == MODE_TERMCLK) || (m == MODE_GATED);
    endfunction

endpackage

// File: rtl/term_polarity.sv
module term_polarity (
    input  logic d_term,
    input  logic e_term,
    input  logic d_inv,
    input  logic e_inv,
    output logic d_eff,
    output logic e_eff
);

    always_comb begin
        d_eff = d_term ^ d_inv;
        e_eff = e_term ^ e_inv;
    end

endmodule

// File: rtl/cell_register.sv
module cell_register
    import mcell_pkg::*;
(
    input  logic       oclk,
    input  logic       rst_term,
    input  cell_mode_e mode,
    input  logic       d_eff,
    input  logic       e_eff,
    input  logic       pl_en,
    input  logic       pl_val,
    output logic       q
);

    logic reg_clk;

    // Term-clocked mode takes its clock from the enable term; all other modes use oclk
    always_comb begin
        unique case (mode)
            MODE_TERMCLK: reg_clk = e_eff;
            default:      reg_clk = oclk;
        endcase
    end

    // Single state bit: load, hold or preload, cleared asynchronously
    always_ff @(posedge reg_clk or posedge rst_term) begin
        if (rst_term) begin
            q <= 1'b0;
        end else if (pl_en) begin
            q <= pl_val;
        end else begin
            unique case (mode)
                MODE_TERMCLK: q <= d_eff;
                MODE_GATED:   q <= e_eff ? d_eff : q;
                default:      q <= q;
            endcase
        end
    end

    // R5: the register reads 0 at every oclk edge while reset is high
    always @(posedge oclk) begin
        if (rst_term) begin
            p_reset_clear_r5: assert (q == 1'b0)
                else $error("register not cleared under reset");
        end
    end

    // R2: gated mode holds when the enable is inactive
    p_gated_hold_r2: assert property (@(posedge oclk) disable iff (rst_term)
        (mode == MODE_GATED && !e_eff && !pl_en) |=> (q == $past(q)));

    // R2: gated mode loads the data term when enabled
    p_gated_load_r2: assert property (@(posedge oclk) disable iff (rst_term)
        (mode == MODE_GATED && e_eff && !pl_en) |=> (q == $past(d_eff)));

    // R9: preload wins over the enable in gated mode
    p_preload_r9: assert property (@(posedge oclk) disable iff (rst_term)
        (mode == MODE_GATED && pl_en) |=> (q == $past(pl_val)));

endmodule

// File: rtl/cell_output.sv
module cell_output
    import mcell_pkg::*;
#(
    parameter bit BURIED = 1'b0
) (
    input  cell_mode_e mode,
    input  logic       d_eff,
    input  logic       q,
    input  logic       oe_term,
    input  logic       pin_in,
    output logic       pin_drive,
    output logic       pin_oe,
    output logic       fb_true,
    output logic       fb_comp,
    output logic       fb_pin
);

    logic cell_val;

    always_comb begin
        cell_val = mode_is_reg(mode) ? q : d_eff;
        fb_true  = cell_val;
        fb_comp  = ~cell_val;
    end

    generate
        if (BURIED) begin : g_buried
            logic unused_bur;
            assign unused_bur = ^{pin_in, oe_term};
            assign pin_drive  = 1'b0;
            assign pin_oe     = 1'b0;
            assign fb_pin     = 1'b0;
        end else begin : g_pin
            assign pin_drive = ~cell_val;
            assign pin_oe    = oe_term;
            assign fb_pin    = pin_in;
        end
    endgenerate

endmodule

// File: rtl/pin_macrocell.sv
module pin_macrocell
    import mcell_pkg::*;
#(
    parameter bit BURIED = 1'b0
) (
    input  logic       oclk,
    input  logic       rst_term,
    input  logic [1:0] mode,
    input  logic       d_inv,
    input  logic       e_inv,
    input  logic       d_term,
    input  logic       e_term,
    input  logic       oe_term,
    input  logic       pl_en,
    input  logic       pl_val,
    input  logic       pin_in,
    output logic       pin_drive,
    output logic       pin_oe,
    output logic       fb_true,
    output logic       fb_comp,
    output logic       fb_pin,
    output logic       diag_q
);

    cell_mode_e mode_e;
    logic       d_eff;
    logic       e_eff;
    logic       q;

    assign mode_e = cell_mode_e'(mode);
    assign diag_q = q;

    term_polarity u_pol (
        .d_term (d_term),
        .e_term (e_term),
        .d_inv  (d_inv),
        .e_inv  (e_inv),
        .d_eff  (d_eff),
        .e_eff  (e_eff)
    );

    cell_register u_reg (
        .oclk     (oclk),
        .rst_term (rst_term),
        .mode     (mode_e),
        .d_eff    (d_eff),
        .e_eff    (e_eff),
        .pl_en    (pl_en),
        .pl_val   (pl_val),
        .q        (q)
    );

    cell_output #(.BURIED(BURIED)) u_out (
        .mode      (mode_e),
        .d_eff     (d_eff),
        .q         (q),
        .oe_term   (oe_term),
        .pin_in    (pin_in),
        .pin_drive (pin_drive),
        .pin_oe    (pin_oe),
        .fb_true   (fb_true),
        .fb_comp   (fb_comp),
        .fb_pin    (fb_pin)
    );

    // R1 / R11: pass-through modes follow the polarised data term
    p_comb_pass_r1: assert property (@(posedge oclk) disable iff (rst_term)
        (mode == 2'b00 || mode == 2'b11) |-> (fb_true == (d_term ^ d_inv)));

    // R5: a cleared register shows high at an enabled pin
    always @(posedge oclk) begin
        if (!BURIED && rst_term && (mode == 2'b01 || mode == 2'b10)) begin
            p_pin_reset_high_r5: assert (pin_drive == 1'b1)
                else $error("pin not high under reset");
        end
    end

endmodule

// File: tb/tb_pin_macrocell.sv
module tb_pin_macrocell;

    logic       oclk = 1'b0;
    logic       rst_term = 1'b1;
    logic [1:0] mode = 2'b10;
    logic       d_inv = 1'b0, e_inv = 1'b0, d_term = 1'b0, e_term = 1'b0;
    logic       oe_term = 1'b1, pl_en = 1'b0, pl_val = 1'b0, pin_in = 1'b0;
    logic       pin_drive, pin_oe, fb_true, fb_comp, fb_pin, diag_q;
    logic       b_drive, b_oe, b_true, b_comp, b_pin, b_diag;

    int checks = 0;
    int failures = 0;

    always #10 oclk = ~oclk;

    pin_macrocell #(.BURIED(1'b0)) dut (
        .oclk(oclk), .rst_term(rst_term), .mode(mode), .d_inv(d_inv), .e_inv(e_inv),
        .d_term(d_term), .e_term(e_term), .oe_term(oe_term), .pl_en(pl_en),
        .pl_val(pl_val), .pin_in(pin_in), .pin_drive(pin_drive), .pin_oe(pin_oe),
        .fb_true(fb_true), .fb_comp(fb_comp), .fb_pin(fb_pin), .diag_q(diag_q)
    );

    pin_macrocell #(.BURIED(1'b1)) dut_bur (
        .oclk(oclk), .rst_term(rst_term), .mode(mode), .d_inv(d_inv), .e_inv(e_inv),
        .d_term(d_term), .e_term(e_term), .oe_term(oe_term), .pl_en(pl_en),
        .pl_val(pl_val), .pin_in(pin_in), .pin_drive(b_drive), .pin_oe(b_oe),
        .fb_true(b_true), .fb_comp(b_comp), .fb_pin(b_pin), .diag_q(b_diag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // {d_term, e_term, d_inv, e_inv, expected register after the edge}
    localparam logic [4:0] VEC [8] = '{
        5'b1_1_0_0_1, 5'b0_0_0_0_1, 5'b0_1_0_0_0, 5'b1_0_0_1_1,
        5'b0_1_0_1_1, 5'b1_1_1_0_0, 5'b0_1_1_0_1, 5'b0_0_0_0_1
    };

    task automatic reset_into(input logic [1:0] m);
        @(negedge oclk);
        rst_term = 1'b1; d_term = 0; e_term = 0; d_inv = 0; e_inv = 0; pl_en = 0;
        mode = m;
        @(negedge oclk);
        rst_term = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        // Reset state, gated mode
        @(negedge oclk);
        chk("R5 reset register", fb_true, 1'b0);
        chk("R5 reset pin high", pin_drive, 1'b1);
        chk("R6 oe follows", pin_oe, 1'b1);
        chk("R10 diag after reset", diag_q, 1'b0);
        rst_term = 1'b0;

        // R2 / R4: gated-mode vector walk
        foreach (VEC[i]) begin
            {d_term, e_term, d_inv, e_inv} = VEC[i][4:1];
            @(posedge oclk);
            @(negedge oclk);
            chk($sformatf("R2 vec %0d fb_true", i), fb_true, VEC[i][0]);
            chk($sformatf("R4 vec %0d pin", i), pin_drive, ~VEC[i][0]);
            chk($sformatf("R10 vec %0d diag", i), diag_q, VEC[i][0]);
        end

        // R5: asynchronous clear between edges, then priority over an edge
        #5 rst_term = 1'b1;
        #1 chk("R5 async clear", fb_true, 1'b0);
        chk("R5 async pin high", pin_drive, 1'b1);
        d_term = 1; e_term = 1;
        @(posedge oclk); @(negedge oclk);
        chk("R5 reset beats edge", fb_true, 1'b0);
        rst_term = 1'b0;

        // R9: preload ignores a disabled enable
        e_term = 0; d_term = 0; pl_en = 1; pl_val = 1;
        @(posedge oclk); @(negedge oclk);
        chk("R9 preload gated", fb_true, 1'b1);
        pl_en = 0;

        // R3: term-clocked mode
        reset_into(2'b01);
        d_term = 1;
        repeat (2) @(posedge oclk);
        @(negedge oclk);
        chk("R3 oclk no effect", fb_true, 1'b0);
        #2 e_term = 1;
        #2 chk("R3 rising enable loads", fb_true, 1'b1);
        d_term = 0;
        #2 e_term = 0;
        #2 chk("R3 falling enable holds", fb_true, 1'b1);
        #2 e_term = 1;
        #2 chk("R3 second load", fb_true, 1'b0);
        e_inv = 1; d_term = 1;
        #2 chk("R4 inverted fall holds", fb_true, 1'b0);
        e_term = 0;
        #2 chk("R4 inverted term clock", fb_true, 1'b1);
        pl_en = 1; pl_val = 0; e_term = 1;
        #2 e_term = 0;
        #2 chk("R9 preload term clock", fb_true, 1'b0);
        pl_en = 0;

        // R1 / R10: pass-through
        reset_into(2'b00);
        d_term = 1;
        #1 chk("R1 pass true", fb_true, 1'b1);
        chk("R1 pass pin", pin_drive, 1'b0);
        d_inv = 1;
        #1 chk("R1 pass inverted", fb_true, 1'b0);
        pl_en = 1; pl_val = 1;
        @(posedge oclk); @(negedge oclk);
        pl_en = 0;
        chk("R10 diag in pass mode", diag_q, 1'b1);
        chk("R10 pass unaffected", fb_true, 1'b0);

        // R11: reserved code behaves as pass-through
        reset_into(2'b11);
        d_term = 1; e_term = 1;
        @(posedge oclk); @(negedge oclk);
        chk("R11 reserved pass", fb_true, 1'b1);
        chk("R11 reserved no load", diag_q, 1'b0);

        // R6 / R7: output enable and pad feedback
        oe_term = 0; pin_in = 1;
        #1 chk("R6 oe low", pin_oe, 1'b0);
        chk("R7 pad feedback", fb_pin, 1'b1);
        chk("R7 direct still valid", fb_true, 1'b1);
        pin_in = 0;
        #1 chk("R7 pad feedback low", fb_pin, 1'b0);

        // R8: buried variant
        oe_term = 1; pin_in = 1;
        #1 chk("R8 buried no oe", b_oe, 1'b0);
        chk("R8 buried fb_pin", b_pin, 1'b0);
        chk("R8 buried true", b_true, 1'b1);
        chk("R8 buried comp", b_comp, 1'b0);

        summary();
    end

endmodule